// File: doc/BRIEF.md
# Four-Channel DMA Trigger and Priority Selector

This block holds the programmed state of four DMA channels and decides which of them a transfer engine should serve next. Software writes a source address, a destination address, a count and a control word for each channel through a simple register port. Turning on a channel's enable bit arms it. The channel then starts either a fixed three cycles later or three cycles after the next vertical-blank pulse, depending on its trigger field. Among the channels that are ready, the lowest-numbered one is presented to the engine, together with its working source, working destination and remaining unit count.

The engine reports each unit it has moved with a one-cycle step pulse. On each step the block advances the selected channel's working addresses and lowers its count. When the count reaches zero the block finishes the channel. It clears the enable bit unless the channel repeats on a vertical-blank trigger. It reloads the destination if the channel is set to do so. It pulses the channel's own interrupt line if interrupts are enabled for that channel. While no channel is ready, the busy output is low so that the processor is free to run.

Top module: `dma_chan_sched`

## Requirements
- R1: Writes to a source (reg 0) or destination (reg 1) register keep only bits 27..1, and every other bit reads back as zero. The register address is {channel[1:0], reg[1:0]}, where reg 2 is the count and reg 3 is the control word.
- R2: A count field of zero loads a count of 0x200000 when the count is 21 bits wide. When the count is 16 bits wide, it loads 0x10000 on channel 3 and 0x4000 on channels 0 to 2.
- R3: The working addresses are copied from the programmed registers only when enable (control bit 0) goes from 0 to 1. Rewriting the control word while the channel is enabled neither re-arms it nor changes its working state.
- R4: Trigger field 0 (control bits 4..3) means an immediate start. The channel becomes selectable exactly 3 cycles after the write edge that enabled it, and its remaining count then equals the programmed count.
- R5: Trigger field 1 means a vertical-blank start. When vblank_i is sampled, each enabled vertical-blank channel with no remaining count becomes selectable 3 cycles later with its programmed count. A pulse that arrives while a count is still remaining has no effect.
- R6: When several channels are selectable, the lowest-numbered one is selected. A lower-numbered channel that becomes ready preempts a transfer that is in progress, and the preempted channel later resumes with its remaining state intact.
- R7: Each step decrements the selected count by one. Each working address moves by 2 bytes, or by 4 bytes when control bit 9 is set. The source mode is in bits 8..7 and the destination mode in bits 6..5: 0 and 3 increment, 1 decrements, 2 holds.
- R8: When the count reaches zero, the enable bit clears if repeat (bit 1) is off or the trigger is immediate. The control register readback shows the cleared bit.
- R9: Destination mode 3 resets the working destination to the programmed destination on completion. The working source is not reset.
- R10: With irq-enable (bit 2) set, completion raises that channel's own irq_o bit for exactly one cycle, in the cycle after the final step edge.
- R11: When no channel is selectable, sel_valid_o and busy_o are low and the work outputs are zero.
- R12: After reset, all registers read as zero, no channel is selected and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | {channel, register} select for writes and reads |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Readback of the addressed register (combinational) |
| vblank_i | input | 1 | Vertical-blank trigger pulse |
| xfer_step_i | input | 1 | Engine moved one unit for the selected channel |
| sel_valid_o | output | 1 | A channel is selected |
| sel_ch_o | output | 2 | Index of the selected channel |
| busy_o | output | 1 | DMA holds the bus; low releases the processor |
| work_src_o | output | 28 | Working source address of the selected channel |
| work_dst_o | output | 28 | Working destination address of the selected channel |
| work_cnt_o | output | 22 | Remaining count of the selected channel |
| irq_o | output | 4 | Per-channel completion interrupt pulses |

## Verification
The hardest case to reach is preemption in the middle of a transfer. It needs a higher-numbered channel that already has partial working state, followed by a lower-numbered channel whose start latency expires while the first one is still selected. The bench first runs channel 1 for one step and then rewrites its control word with enable still set, to show that nothing re-arms. It then arms channel 0 and samples the selection on each of the three latency cycles. After channel 0 finishes, the bench confirms that channel 1 is selected again with its partial addresses and count unchanged. A second instance built with a 16-bit count covers the channel-dependent zero-count values. The full set of address-mode and width combinations is swept on channel 0.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {TRIG_NOW = 2'd0, TRIG_VBL = 2'd1, TRIG_RSV2 = 2'd2, TRIG_RSV3 = 2'd3} trig_e;
  typedef enum logic [1:0] {ADR_INC = 2'd0, ADR_DEC = 2'd1, ADR_FIX = 2'd2, ADR_INC_RLD = 2'd3} adr_mode_e;

  // bit 9 .. bit 0
  typedef struct packed {
    logic      wide;
    adr_mode_e src_mode;
    adr_mode_e dst_mode;
    trig_e     trig;
    logic      irq_en;
    logic      repeat_en;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W = 10;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int CNT_W     = 21,
  parameter int CH_IDX    = 0,
  parameter int START_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_cnt_i,
  input  logic              wr_ctrl_i,
  input  logic [31:0]       wdata_i,
  input  logic              vblank_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_raw_o,
  output ctrl_t             ctrl_o,
  output logic              eligible_o,
  output logic [ADDR_W-1:0] work_src_o,
  output logic [ADDR_W-1:0] work_dst_o,
  output logic [CNT_W:0]    pend_o,
  output logic              irq_o
);
  localparam int PEND_W = CNT_W + 1;
  localparam int DLY_W  = $clog2(START_LAT + 1);
  localparam logic [PEND_W-1:0] ONE = PEND_W'(1);
  // short count variant: only the last channel gets the full range
  localparam logic [PEND_W-1:0] MAX_CNT =
    (CNT_W == 16 && CH_IDX != 3) ? (ONE << (CNT_W - 2)) : (ONE << CNT_W);

  logic [ADDR_W-1:0] src_q, dst_q, work_src_q, work_dst_q;
  logic [ADDR_W-1:0] nxt_src, nxt_dst, stride;
  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q, load_cnt;
  logic [DLY_W-1:0]  dly_q;
  ctrl_t             ctrl_q, new_ctrl;
  logic              irq_q, eligible, step_go, done, arm, vbl_arm, clear_en;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[31:ADDR_W];
  assign new_ctrl     = ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign load_cnt     = (cnt_q == '0) ? MAX_CNT : {1'b0, cnt_q};
  assign eligible     = ctrl_q.en && (pend_q != '0) && (dly_q == '0);
  assign step_go      = step_i && eligible;
  assign done         = step_go && (pend_q == ONE);
  assign arm          = wr_ctrl_i && !ctrl_q.en && new_ctrl.en;
  assign vbl_arm      = vblank_i && ctrl_q.en && (ctrl_q.trig == TRIG_VBL) &&
                        (pend_q == '0) && (dly_q == '0);
  assign clear_en     = !ctrl_q.repeat_en || (ctrl_q.trig == TRIG_NOW);
  assign stride       = ctrl_q.wide ? ADDR_W'(4) : ADDR_W'(2);

  function automatic logic [ADDR_W-1:0] adv(input logic [ADDR_W-1:0] a,
                                            input adr_mode_e m,
                                            input logic [ADDR_W-1:0] s);
    case (m)
      ADR_DEC: adv = a - s;
      ADR_FIX: adv = a;
      default: adv = a + s;
    endcase
  endfunction

  assign nxt_src = adv(work_src_q, ctrl_q.src_mode, stride);
  assign nxt_dst = adv(work_dst_q, ctrl_q.dst_mode, stride);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      ctrl_q     <= '0;
      work_src_q <= '0;
      work_dst_q <= '0;
      pend_q     <= '0;
      dly_q      <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_src_i) src_q <= {wdata_i[ADDR_W-1:1], 1'b0};
      if (wr_dst_i) dst_q <= {wdata_i[ADDR_W-1:1], 1'b0};
      if (wr_cnt_i) cnt_q <= wdata_i[CNT_W-1:0];

      if (dly_q != '0) begin
        dly_q <= dly_q - DLY_W'(1);
        if (dly_q == DLY_W'(1)) pend_q <= load_cnt;
      end else if (vbl_arm) begin
        dly_q <= DLY_W'(START_LAT);
      end

      if (step_go) begin
        pend_q     <= pend_q - ONE;
        work_src_q <= nxt_src;
        work_dst_q <= (done && ctrl_q.dst_mode == ADR_INC_RLD) ? dst_q : nxt_dst;
        if (done) begin
          irq_q <= ctrl_q.irq_en;
          if (clear_en) ctrl_q.en <= 1'b0;
        end
      end

      if (wr_ctrl_i) begin
        ctrl_q <= new_ctrl;
        if (arm) begin
          work_src_q <= src_q;
          work_dst_q <= dst_q;
          pend_q     <= '0;
          dly_q      <= (new_ctrl.trig == TRIG_NOW) ? DLY_W'(START_LAT) : '0;
        end
      end
    end
  end

  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_raw_o  = cnt_q;
  assign ctrl_o     = ctrl_q;
  assign eligible_o = eligible;
  assign work_src_o = work_src_q;
  assign work_dst_o = work_dst_q;
  assign pend_o     = pend_q;
  assign irq_o      = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R10
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && ctrl_q.en && new_ctrl.en && !step_go) |=>
      ($stable(work_src_q) && $stable(work_dst_q))); // R3
  AST_LOAD_AFTER_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q != '0) && ($past(pend_q) == '0)) |-> ($past(dly_q) == DLY_W'(1))); // R4
  AST_DONE_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wr_ctrl_i && (!ctrl_q.repeat_en || ctrl_q.trig == TRIG_NOW)) |=> !ctrl_q.en); // R8
  AST_DST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wr_ctrl_i && ctrl_q.dst_mode == ADR_INC_RLD) |=> (work_dst_q == $past(dst_q))); // R9
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] grant_o,
  output logic            valid_o,
  output logic [CH_W-1:0] idx_o
);
  assign grant_o = req_i & (~req_i + N_CH'(1));
  assign valid_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
  import dma_sched_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int ADDR_W    = 28,
  parameter int CNT_W     = 21,
  parameter int START_LAT = 3,
  localparam int CH_W     = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CH_W+1:0]   reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              vblank_i,
  input  logic              xfer_step_i,
  output logic              sel_valid_o,
  output logic [CH_W-1:0]   sel_ch_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] work_src_o,
  output logic [ADDR_W-1:0] work_dst_o,
  output logic [CNT_W:0]    work_cnt_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [CH_W-1:0]   ch_sel;
  logic [1:0]        reg_sel;
  logic [ADDR_W-1:0] src_a [N_CH];
  logic [ADDR_W-1:0] dst_a [N_CH];
  logic [ADDR_W-1:0] wsrc_a [N_CH];
  logic [ADDR_W-1:0] wdst_a [N_CH];
  logic [CNT_W-1:0]  cnt_a [N_CH];
  logic [CNT_W:0]    pend_a [N_CH];
  ctrl_t             ctrl_a [N_CH];
  logic [N_CH-1:0]   elig, grant;
  logic              sel_valid;
  logic [CH_W-1:0]   sel_idx;

  assign ch_sel  = reg_addr_i[CH_W+1:2];
  assign reg_sel = reg_addr_i[1:0];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = reg_we_i && (ch_sel == CH_W'(g));
    dma_chan #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_IDX(g), .START_LAT(START_LAT)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_src_i   (hit && reg_sel == REG_SRC),
      .wr_dst_i   (hit && reg_sel == REG_DST),
      .wr_cnt_i   (hit && reg_sel == REG_CNT),
      .wr_ctrl_i  (hit && reg_sel == REG_CTRL),
      .wdata_i    (reg_wdata_i),
      .vblank_i   (vblank_i),
      .step_i     (xfer_step_i && grant[g]),
      .src_o      (src_a[g]),
      .dst_o      (dst_a[g]),
      .cnt_raw_o  (cnt_a[g]),
      .ctrl_o     (ctrl_a[g]),
      .eligible_o (elig[g]),
      .work_src_o (wsrc_a[g]),
      .work_dst_o (wdst_a[g]),
      .pend_o     (pend_a[g]),
      .irq_o      (irq_o[g])
    );
  end

  dma_prio_arb #(.N_CH(N_CH)) u_arb (
    .req_i   (elig),
    .grant_o (grant),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  always_comb begin
    case (reg_sel)
      REG_SRC: reg_rdata_o = {{(32-ADDR_W){1'b0}}, src_a[ch_sel]};
      REG_DST: reg_rdata_o = {{(32-ADDR_W){1'b0}}, dst_a[ch_sel]};
      REG_CNT: reg_rdata_o = {{(32-CNT_W){1'b0}}, cnt_a[ch_sel]};
      default: reg_rdata_o = {{(32-CTRL_W){1'b0}}, ctrl_a[ch_sel]};
    endcase
  end

  assign sel_valid_o = sel_valid;
  assign sel_ch_o    = sel_idx;
  assign busy_o      = sel_valid;
  assign work_src_o  = sel_valid ? wsrc_a[sel_idx] : '0;
  assign work_dst_o  = sel_valid ? wdst_a[sel_idx] : '0;
  assign work_cnt_o  = sel_valid ? pend_a[sel_idx] : '0;

  AST_SEL_IS_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> elig[sel_ch_o]); // R6
  AST_SEL_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> ((elig & ((N_CH'(1) << sel_ch_o) - N_CH'(1))) == '0)); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R6
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> (!busy_o && !sel_valid_o && work_cnt_o == '0)); // R11
endmodule

// File: tb/tb_dma_chan_sched.sv
module tb_dma_chan_sched;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h1, REP = 32'h2, IRQ = 32'h4, VBL = 32'h8, WIDE = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata16;
  logic        vblank = 1'b0, step = 1'b0;
  logic        sel_valid, busy, sel_valid16, busy16;
  logic [1:0]  sel_ch, sel_ch16;
  logic [27:0] wsrc, wdst, wsrc16, wdst16;
  logic [21:0] wcnt;
  logic [16:0] wcnt16;
  logic [3:0]  irq, irq16;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .vblank_i(vblank), .xfer_step_i(step), .sel_valid_o(sel_valid),
    .sel_ch_o(sel_ch), .busy_o(busy), .work_src_o(wsrc), .work_dst_o(wdst),
    .work_cnt_o(wcnt), .irq_o(irq));

  dma_chan_sched #(.CNT_W(16)) dut_n16 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata16), .vblank_i(vblank), .xfer_step_i(step), .sel_valid_o(sel_valid16),
    .sel_ch_o(sel_ch16), .busy_o(busy16), .work_src_o(wsrc16), .work_dst_o(wdst16),
    .work_cnt_o(wcnt16), .irq_o(irq16));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = {ch, r}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic [1:0] r, output logic [31:0] d);
    addr = {ch, r};
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step1();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic vbl1();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  function automatic int off(input int m);
    case (m)
      1: off = -1;
      2: off = 0;
      default: off = 1;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R12 reset state
    chk("R12 sel_valid", {31'b0, sel_valid}, 0);
    chk("R12 irq", {28'b0, irq}, 0);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        rd(2'(c), 2'(r), d);
        chk("R12 reg reset", d, 0);
      end
    chk("R11 busy idle", {31'b0, busy}, 0);

    // R1 address masking
    for (int c = 0; c < 4; c++) begin
      wr(2'(c), 2'd0, 32'hFFFF_FFFF);
      wr(2'(c), 2'd1, 32'h1234_5677);
      rd(2'(c), 2'd0, d); chk("R1 src mask", d, 32'h0FFF_FFFE);
      rd(2'(c), 2'd1, d); chk("R1 dst mask", d, 32'h0234_5676);
    end

    // R2 zero count, R4 latency
    for (int c = 1; c < 4; c += 2) begin
      wr(2'(c), 2'd2, 0);
      wr(2'(c), 2'd0, 32'h100);
      wr(2'(c), 2'd1, 32'h200);
      wr(2'(c), 2'd3, EN);
      idle(2);
      chk("R4 not yet eligible", {31'b0, sel_valid}, 0);
      idle(1);
      chk("R4 eligible at 3", {31'b0, sel_valid}, 1);
      chk("R4 sel ch", {30'b0, sel_ch}, 32'(c));
      chk("R2 zero count 21b", {10'b0, wcnt}, 32'h200000);
      chk("R2 zero count 16b", {15'b0, wcnt16}, (c == 3) ? 32'h10000 : 32'h4000);
      wr(2'(c), 2'd3, 0);
      chk("R11 idle valid", {31'b0, sel_valid}, 0);
      chk("R11 idle busy", {31'b0, busy}, 0);
      chk("R11 idle cnt", {10'b0, wcnt}, 0);
    end

    // R7 address modes and widths, R8 completion clear
    for (int sm = 0; sm < 4; sm++)
      for (int dm = 0; dm < 3; dm++)
        for (int w = 0; w < 2; w++) begin
          int stride;
          stride = (w != 0) ? 4 : 2;
          wr(2'd0, 2'd0, 32'h1000);
          wr(2'd0, 2'd1, 32'h2000);
          wr(2'd0, 2'd2, 3);
          wr(2'd0, 2'd3, EN | (32'(dm) << 5) | (32'(sm) << 7) | ((w != 0) ? WIDE : 0));
          idle(3);
          chk("R4 cnt loaded", {10'b0, wcnt}, 3);
          step1(); step1();
          chk("R7 src", {4'b0, wsrc}, 32'(32'h1000 + 2 * off(sm) * stride));
          chk("R7 dst", {4'b0, wdst}, 32'(32'h2000 + 2 * off(dm) * stride));
          chk("R7 cnt", {10'b0, wcnt}, 1);
          step1();
          chk("R8 done idle", {31'b0, sel_valid}, 0);
          rd(2'd0, 2'd3, d);
          chk("R8 en cleared", {31'b0, d[0]}, 0);
        end

    // R5 vblank arming, R8 repeat keeps enable, R9 reload
    wr(2'd2, 2'd0, 32'h1000);
    wr(2'd2, 2'd1, 32'h2000);
    wr(2'd2, 2'd2, 2);
    wr(2'd2, 2'd3, EN | REP | VBL | (32'd3 << 5));
    idle(5);
    chk("R5 waits for vblank", {31'b0, sel_valid}, 0);
    vbl1();
    idle(2);
    chk("R5 not yet eligible", {31'b0, sel_valid}, 0);
    idle(1);
    chk("R5 eligible", {31'b0, sel_valid}, 1);
    chk("R5 cnt", {10'b0, wcnt}, 2);
    step1();
    chk("R7 dst inc", {4'b0, wdst}, 32'h2002);
    step1();
    chk("R8 repeat idle", {31'b0, sel_valid}, 0);
    rd(2'd2, 2'd3, d);
    chk("R8 repeat keeps en", {31'b0, d[0]}, 1);
    vbl1();
    idle(3);
    chk("R9 dst reloaded", {4'b0, wdst}, 32'h2000);
    chk("R9 src not reloaded", {4'b0, wsrc}, 32'h1004);
    step1();
    vbl1();
    idle(4);
    chk("R5 vblank ignored while pending", {10'b0, wcnt}, 1);
    step1();
    wr(2'd2, 2'd3, 0);

    // R10 irq pulse, R8 immediate clears even with repeat
    wr(2'd2, 2'd2, 1);
    wr(2'd2, 2'd3, EN | REP | IRQ);
    idle(3);
    step1();
    chk("R10 irq raised", {28'b0, irq}, 32'h4);
    idle(1);
    chk("R10 irq one cycle", {28'b0, irq}, 0);
    rd(2'd2, 2'd3, d);
    chk("R8 immediate clears", {31'b0, d[0]}, 0);

    // R3 no re-arm, R6 preemption
    wr(2'd1, 2'd0, 32'h100);
    wr(2'd1, 2'd1, 32'h200);
    wr(2'd1, 2'd2, 5);
    wr(2'd1, 2'd3, EN);
    idle(3);
    step1();
    chk("R7 ch1 src", {4'b0, wsrc}, 32'h102);
    wr(2'd1, 2'd0, 32'h800);
    wr(2'd1, 2'd3, EN);
    idle(4);
    chk("R3 src kept", {4'b0, wsrc}, 32'h102);
    chk("R3 cnt kept", {10'b0, wcnt}, 4);
    wr(2'd0, 2'd0, 32'h40);
    wr(2'd0, 2'd1, 32'h80);
    wr(2'd0, 2'd2, 2);
    wr(2'd0, 2'd3, EN);
    idle(2);
    chk("R6 ch1 still selected", {30'b0, sel_ch}, 1);
    idle(1);
    chk("R6 ch0 preempts", {30'b0, sel_ch}, 0);
    chk("R6 ch0 cnt", {10'b0, wcnt}, 2);
    step1(); step1();
    chk("R6 ch1 resumes", {30'b0, sel_ch}, 1);
    chk("R6 ch1 cnt", {10'b0, wcnt}, 4);
    chk("R6 ch1 src", {4'b0, wsrc}, 32'h102);
    wr(2'd1, 2'd3, 0);
    chk("R11 released", {31'b0, busy}, 0);

    finish_run();
  end
endmodule